// File: doc/BRIEF.md
# Non-Maskable Trap Recognizer

This block decides when a non-maskable trap request should be serviced by a processor core. The trap input is asynchronous. It passes through a synchronizer, and the block then requires two things together: a rising edge on the input, and the input still being high when the core marks its recognition point with a sample strobe. The core raises that strobe once per instruction, on the clock before the address strobe that follows the instruction's last machine cycle.

When both conditions are met, the block asserts a pending-service flag and emits a one-cycle pulse asking the core to insert an internal restart. While the flag is pending, it presents the fixed restart vector 0x0024. The flag stays up until the core acknowledges it. While it is pending, any maskable interrupt request from outside is suppressed, because the trap has the highest priority of all sources.

After a recognition the trap is locked out. It becomes eligible again only once the input has returned low and then risen again. A pulse that falls before the sample point is discarded.

Top module: `nmi_trap_recognizer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears its synchronizer, armed state and pending state. After reset, `svc_pending`, `restart_pulse` and `mask_req_out` are 0 (with `mask_req_in` low) and `restart_vec` is 0.
- R2: A rise of `trap_in` that is held high is recognized at the first clock edge with `sample_stb` high at least three edges after the rise was captured. Recognition is one synchronizer edge, one level edge and one arming edge. After the recognizing edge, `svc_pending` is 1.
- R3: `restart_vec` equals 0x0024 whenever `svc_pending` is 1, and equals 0 otherwise.
- R4: If `trap_in` returns low before the sample strobe, the earlier rise is discarded and a later strobe does not recognize it.
- R5: A sample strobe has no effect in two cases: while the synchronized input is low, and before the arming edge that follows a rise.
- R6: After a recognition, further strobes are ignored while `trap_in` stays high. After a low level followed by a new rise, the trap can be recognized again.
- R7: `svc_pending` stays 1 from recognition until a clock edge with `core_ack` high. It is 0 after that edge.
- R8: While `svc_pending` is 1, `mask_req_out` is 0. Otherwise `mask_req_out` follows `mask_req_in`.
- R9: `restart_pulse` is 1 for exactly the one cycle after the recognizing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_in | input | 1 | Asynchronous non-maskable trap request |
| sample_stb | input | 1 | Recognition point marker from the core |
| core_ack | input | 1 | Core has taken the restart; clears pending |
| mask_req_in | input | 1 | Maskable interrupt request from lower-priority logic |
| svc_pending | output | 1 | Trap recognized and awaiting acknowledge |
| restart_pulse | output | 1 | One-cycle request to insert the internal restart |
| restart_vec | output | 16 | Restart vector, 0x0024 while pending |
| mask_req_out | output | 1 | Maskable request after trap override |

## Verification
The assertions assume three things about the inputs. `rst_n` is applied synchronously. `core_ack` is a single-cycle acknowledge, raised only after a pending service. `sample_stb` is a one-cycle mark, not a held level. The stimulus changes every input on the falling clock edge, so the synchronizer always samples settled values. It keeps `trap_in` high or low for whole cycles, with gaps long enough that each edge is seen by the synchronizer. It raises the acknowledge only after it has observed a pending service.

// File: rtl/nmi_trap_pkg.sv
// Package: nmi_trap_pkg
// Shared constants for the non-maskable trap recognizer.
// Assumes a 16-bit restart address space.
package nmi_trap_pkg;
    localparam int unsigned TRAP_VEC_W     = 16;
    localparam logic [15:0] TRAP_RESTART   = 16'h0024;
    localparam int unsigned TRAP_SYNC_MIN  = 2;
endpackage

// File: rtl/nmi_trap_sync.sv
// Module: nmi_trap_sync
// Brings the asynchronous trap pin into the clock domain through a chain
// of STAGES flops, then registers the result once more so that a one-cycle
// rising-edge indication can be formed.
// Assumes STAGES >= 2 and a synchronous active-low reset.
module nmi_trap_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the raw pin in the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                // Shift the value one stage further.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[LAST];
    end

    assign level = chain_q[LAST];
    assign rise  = chain_q[LAST] & ~prev_q;

    // R2: a rise indication lasts at most one cycle.
    assert_rise_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/nmi_trap_arm.sv
// Module: nmi_trap_arm
// Holds the edge-armed flag. The flag is set by a synchronized rising edge.
// It is dropped if the level falls before the sample point, and dropped
// when the trap is recognized. Dropping it on recognition is what locks
// the trap out until the next low-then-high sequence.
// Assumes level/rise come from nmi_trap_sync.
module nmi_trap_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic rise,
    input  logic sample_stb,
    output logic recognize
);
    logic armed_q;

    assign recognize = sample_stb & armed_q & level;

    // Update the armed flag from edge, level and recognition.
    always_ff @(posedge clk) begin
        if (!rst_n)         armed_q <= 1'b0;
        else if (rise)      armed_q <= 1'b1;
        else if (!level)    armed_q <= 1'b0;
        else if (recognize) armed_q <= 1'b0;
    end

    // R4: a low level at the sample point removes the arming.
    assert_drop_on_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !level && !rise) |=> !armed_q);
    // R6: recognition locks the trap out.
    assert_lockout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        recognize |=> !armed_q);
    // R5: arming only ever follows a rise.
    assert_arm_needs_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !rise) |=> !armed_q);
endmodule

// File: rtl/nmi_trap_svc.sv
// Module: nmi_trap_svc
// Keeps the pending-service flag until the core acknowledges it.
// Emits the one-cycle restart request, presents the fixed vector, and
// blocks the maskable request while the trap is pending.
// Assumes recognize is a single-cycle indication.
module nmi_trap_svc #(
    parameter int unsigned         VEC_W = 16,
    parameter logic [VEC_W-1:0]    VEC   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             recognize,
    input  logic             core_ack,
    input  logic             mask_req_in,
    output logic             pending,
    output logic             pulse,
    output logic [VEC_W-1:0] vec,
    output logic             mask_out
);
    logic pending_q;
    logic pulse_q;

    // Set pending on recognition; clear on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)         pending_q <= 1'b0;
        else if (recognize) pending_q <= 1'b1;
        else if (core_ack)  pending_q <= 1'b0;
    end

    // Register the single-cycle restart request.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= recognize;
    end

    assign pending  = pending_q;
    assign pulse    = pulse_q;
    assign vec      = pending_q ? VEC : '0;
    assign mask_out = mask_req_in & ~pending_q;

    // R9: the restart request is one cycle long.
    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);
    // R2: a new pending service always comes with a restart request.
    assert_pend_with_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending_q) |-> pulse_q);
    // R7: pending holds until acknowledged.
    assert_hold_until_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && !core_ack) |=> pending_q);
    // R7: acknowledge without new recognition clears pending.
    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ack && !recognize) |=> !pending_q);
endmodule

// File: rtl/nmi_trap_recognizer.sv
// Module: nmi_trap_recognizer
// Top level. Recognizes a non-maskable trap on edge plus sustained level
// at the core's sample point, then requests an internal restart at a fixed
// vector and overrides maskable requests until acknowledged.
// Assumes sample_stb and core_ack are synchronous one-cycle marks.
module nmi_trap_recognizer
    import nmi_trap_pkg::*;
#(
    parameter int unsigned             SYNC_STAGES = TRAP_SYNC_MIN,
    parameter int unsigned             VEC_W       = TRAP_VEC_W,
    parameter logic [VEC_W-1:0]        RESTART_VEC = VEC_W'(TRAP_RESTART)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_in,
    input  logic             sample_stb,
    input  logic             core_ack,
    input  logic             mask_req_in,
    output logic             svc_pending,
    output logic             restart_pulse,
    output logic [VEC_W-1:0] restart_vec,
    output logic             mask_req_out
);
    logic sync_level;
    logic sync_rise;
    logic recognize;

    nmi_trap_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (trap_in),
        .level    (sync_level),
        .rise     (sync_rise)
    );

    nmi_trap_arm arm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (sync_level),
        .rise       (sync_rise),
        .sample_stb (sample_stb),
        .recognize  (recognize)
    );

    nmi_trap_svc #(.VEC_W(VEC_W), .VEC(RESTART_VEC)) svc_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .recognize   (recognize),
        .core_ack    (core_ack),
        .mask_req_in (mask_req_in),
        .pending     (svc_pending),
        .pulse       (restart_pulse),
        .vec         (restart_vec),
        .mask_out    (mask_req_out)
    );

    // R8: a maskable request never passes while the trap is pending.
    assert_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
        svc_pending |-> !mask_req_out);
    // R3: the vector is only ever the restart address or zero.
    assert_vec_values_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_vec == RESTART_VEC) || (restart_vec == '0));
endmodule

// File: tb/nmi_trap_recognizer_tb.sv
module nmi_trap_recognizer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_in = 1'b0;
    logic        sample_stb = 1'b0;
    logic        core_ack = 1'b0;
    logic        mask_req_in = 1'b0;
    logic        svc_pending;
    logic        restart_pulse;
    logic [15:0] restart_vec;
    logic        mask_req_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    nmi_trap_recognizer dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .trap_in       (trap_in),
        .sample_stb    (sample_stb),
        .core_ack      (core_ack),
        .mask_req_in   (mask_req_in),
        .svc_pending   (svc_pending),
        .restart_pulse (restart_pulse),
        .restart_vec   (restart_vec),
        .mask_req_out  (mask_req_out)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    // Advance one cycle; return just after the falling edge.
    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic strobe();
        sample_stb = 1'b1;
        tick();
        sample_stb = 1'b0;
    endtask

    task automatic do_ack();
        core_ack = 1'b1;
        tick();
        core_ack = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick();
        check("R1 pending after reset", 16'(svc_pending), 16'd0);
        check("R1 pulse after reset", 16'(restart_pulse), 16'd0);
        check("R1 vec after reset", restart_vec, 16'h0000);
        check("R1 mask_out after reset", 16'(mask_req_out), 16'd0);
    endtask

    task automatic t_recognize();
        mask_req_in = 1'b1;
        tick();
        check("R8 mask passes when idle", 16'(mask_req_out), 16'd1);
        trap_in = 1'b1;
        tick(4);
        check("R2 no pending before strobe", 16'(svc_pending), 16'd0);
        strobe();
        check("R2 pending after strobe", 16'(svc_pending), 16'd1);
        check("R9 pulse high", 16'(restart_pulse), 16'd1);
        check("R3 vector while pending", restart_vec, 16'h0024);
        check("R8 mask blocked", 16'(mask_req_out), 16'd0);
        tick();
        check("R9 pulse one cycle", 16'(restart_pulse), 16'd0);
        tick(3);
        check("R7 pending held without ack", 16'(svc_pending), 16'd1);
        do_ack();
        check("R7 pending cleared by ack", 16'(svc_pending), 16'd0);
        check("R3 vector zero when idle", restart_vec, 16'h0000);
        check("R8 mask passes after ack", 16'(mask_req_out), 16'd1);
        mask_req_in = 1'b0;
    endtask

    task automatic t_lockout();
        // trap_in still high from the previous scenario
        strobe();
        check("R6 no recognition while held high", 16'(svc_pending), 16'd0);
        check("R6 no pulse while held high", 16'(restart_pulse), 16'd0);
        trap_in = 1'b0;
        tick(4);
        trap_in = 1'b1;
        tick(4);
        strobe();
        check("R6 re-armed after low then high", 16'(svc_pending), 16'd1);
        do_ack();
    endtask

    task automatic t_short_pulse();
        trap_in = 1'b0;
        tick(4);
        trap_in = 1'b1;
        tick();
        trap_in = 1'b0;
        tick(5);
        strobe();
        check("R4 short pulse ignored", 16'(svc_pending), 16'd0);
        check("R4 short pulse no restart", 16'(restart_pulse), 16'd0);
    endtask

    task automatic t_early_and_low();
        strobe();
        check("R5 strobe with input low", 16'(svc_pending), 16'd0);
        trap_in = 1'b1;
        tick(2);
        strobe();
        check("R5 strobe before arming", 16'(svc_pending), 16'd0);
        tick();
        strobe();
        check("R2 later strobe recognizes", 16'(svc_pending), 16'd1);
        check("R9 pulse on late recognition", 16'(restart_pulse), 16'd1);
        do_ack();
    endtask

    task automatic t_reset_mid();
        trap_in = 1'b0;
        tick(4);
        trap_in = 1'b1;
        tick(4);
        strobe();
        check("R2 pending before reset", 16'(svc_pending), 16'd1);
        rst_n = 1'b0;
        tick();
        check("R1 reset clears pending", 16'(svc_pending), 16'd0);
        check("R1 reset clears vector", restart_vec, 16'h0000);
        rst_n = 1'b1;
        trap_in = 1'b0;
        tick(3);
    endtask

    initial begin
        tick();
        t_reset();
        t_recognize();
        t_lockout();
        t_short_pulse();
        t_early_and_low();
        t_reset_mid();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule